// File: doc/BRIEF.md
# Throttled Interrupt Cause Controller

This block collects interrupt causes from several sources into a cause register, compares them against a software mask, and drives one level interrupt line to a host. It also spaces interrupts out. After an interrupt has been delivered, further deliveries are held back until a programmable interval has passed. That interval is counted from the moment of the last delivery, not from the moment a new request arrives. A request that comes in after the interval has run out is delivered at once. A request that comes in earlier is delivered in the exact cycle the interval runs out.

Sources post a cause vector, and may mark the post as urgent so that it skips the throttle. Each real delivery produces a one-cycle pulse, which neighbouring delay timers use to cancel themselves. The host reads the cause register through a read strobe, and the read clears it. The host also writes the mask. The interval input is given in units of 2^TICK_LOG2 clock cycles, which is 256 ns at 250 MHz with the default TICK_LOG2 = 6.

The control is a three-state machine:
- **IDLE**: line low, nothing armed.
- **ARMED**: a deferred delivery is pending.
- **ASSERTED**: line high.

It has six transitions:
- **post-deliver**: any state to ASSERTED, on a post once the interval has elapsed, or an urgent post, or an interval of zero.
- **post-defer**: IDLE to ARMED, on a post inside the interval.
- **timer-fire**: ARMED to ASSERTED, or to IDLE if nothing unmasked is pending.
- **mask-arm**: IDLE to ARMED, when a mask write uncovers a pending cause.
- **clear-drop**: ARMED or ASSERTED to IDLE, when a read or a mask write leaves no unmasked cause.
- **stay**: every other case.

Top module: `ithr_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `deliver_pulse` is 0, the cause and mask registers are 0 (so `rd_data` reads 0) and `attempt_count` is 0.
- R2: A post ORs `post_bits` into the cause register whatever the mask holds. `rd_data[CAUSE_W-1:0]` shows the new bits in the following cycle, and `rd_data[CAUSE_W]` is the line-asserted flag.
- R3: With `itr_interval` = 0, a post whose bits meet the mask raises `irq` and `deliver_pulse` in the next cycle.
- R4: A post with `post_urgent` = 1 is a delivery attempt at once, whatever time has passed since the last delivery.
- R5: A post that arrives fewer than W = `itr_interval`·2^TICK_LOG2 cycles after the last delivery is deferred. Its `deliver_pulse` appears exactly W+1 cycles after the previous `deliver_pulse`.
- R6: A post that arrives W or more cycles after the last delivery is delivered in the next cycle.
- R7: Further posts while a deferred delivery is armed add their bits but do not move the armed time or add a delivery.
- R8: Each delivery attempt, from a qualifying post or a timer fire, adds 1 to `attempt_count`. This happens even when the cause AND mask is zero, and in that case `irq` and `deliver_pulse` stay low.
- R9: On a delivery, `deliver_pulse` is high for that cycle, `irq` goes high and `rd_data[CAUSE_W]` reads 1.
- R10: With `cause_rd` high, `rd_data` shows the current value in that cycle. In the next cycle the cause bits read 0 and `irq` is low, unless a post arrived in the same cycle.
- R11: A mask write that leaves the cause AND mask at zero cancels an armed deferred delivery, so no pulse and no attempt follow. It also drops `irq` in the next cycle.
- R12: A mask write that uncovers a pending cause while the block is IDLE arms a delivery. Its `deliver_pulse` appears W+1 cycles after the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| itr_interval | input | IVL_W | Throttle interval, in units of 2^TICK_LOG2 cycles |
| post_valid | input | 1 | Post strobe |
| post_bits | input | CAUSE_W | Cause bits to OR in |
| post_urgent | input | 1 | Post skips the throttle |
| cause_rd | input | 1 | Read-and-clear strobe for the cause register |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | CAUSE_W | New mask value |
| rd_data | output | CAUSE_W+1 | {line asserted, cause bits} |
| irq | output | 1 | Level interrupt to the host |
| deliver_pulse | output | 1 | One-cycle pulse per real delivery |
| attempt_count | output | CNT_W | Delivery attempt counter |

## Verification
The bench builds the block with CAUSE_W = 8, IVL_W = 8 and TICK_LOG2 = 2. With these values one interval unit is four cycles, and an interval of 3 gives a window of 12 cycles. Posting inside and after the window, the mask-driven arming and the cancel case therefore all fit into a few dozen cycles each. The short unit also keeps the exact timing of the deferred pulse (W+1 cycles after the previous one) easy to predict from the bench's own cycle counter.

// File: rtl/ithr_pkg.sv
package ithr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_ASSERTED = 2'd2
    } ithr_state_e;
endpackage

// File: rtl/ithr_age.sv
// Cycles elapsed since the last delivery; saturates so a long idle never wraps.
module ithr_age #(
    parameter int AGE_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [AGE_W-1:0] age
);
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= '1;
        else if (restart)        age <= '0;
        else if (age != '1)      age <= age + AGE_W'(1);
    end
endmodule

// File: rtl/ithr_countdown.sv
// Remaining cycles until a deferred delivery fires.
module ithr_countdown #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_zero
);
    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (!rst_n)           rem <= '0;
        else if (load)        rem <= load_val;
        else if (rem != '0)   rem <= rem - CNT_W'(1);
    end

    assign at_zero = (rem == '0);
endmodule

// File: rtl/ithr_cause_regs.sv
// Cause and mask registers; exposes the values they take at the next edge.
module ithr_cause_regs #(
    parameter int CAUSE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [CAUSE_W-1:0] set_bits,
    input  logic               mask_wr,
    input  logic [CAUSE_W-1:0] mask_wdata,
    output logic [CAUSE_W-1:0] cause,
    output logic [CAUSE_W-1:0] cause_nx,
    output logic [CAUSE_W-1:0] mask_nx
);
    logic [CAUSE_W-1:0] mask_q;

    // clear acts first, then the new bits are merged in
    assign cause_nx = (clear ? '0 : cause) | set_bits;
    assign mask_nx  = mask_wr ? mask_wdata : mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause  <= '0;
            mask_q <= '0;
        end else begin
            cause  <= cause_nx;
            mask_q <= mask_nx;
        end
    end
endmodule

// File: rtl/ithr_ctrl.sv
module ithr_ctrl
    import ithr_pkg::*;
#(
    parameter int CAUSE_W   = 8,
    parameter int IVL_W     = 16,
    parameter int TICK_LOG2 = 6,
    parameter int CNT_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IVL_W-1:0]   itr_interval,
    input  logic               post_valid,
    input  logic [CAUSE_W-1:0] post_bits,
    input  logic               post_urgent,
    input  logic               cause_rd,
    input  logic               mask_wr,
    input  logic [CAUSE_W-1:0] mask_wdata,
    output logic [CAUSE_W:0]   rd_data,
    output logic               irq,
    output logic               deliver_pulse,
    output logic [CNT_W-1:0]   attempt_count
);
    localparam int WIN_W = IVL_W + TICK_LOG2;

    ithr_state_e        state, state_nx;
    logic [CAUSE_W-1:0] cause, cause_nx, mask_nx;
    logic [WIN_W-1:0]   age, window, post_load, mask_load, load_val;
    logic               cd_zero, load, do_deliver;
    logic               elapsed, fire, attempt, pending;

    assign window    = {itr_interval, {TICK_LOG2{1'b0}}};
    // fire lands in the cycle where age would first reach window
    assign post_load = window - age - WIN_W'(1);
    assign mask_load = (window == '0) ? '0 : window - WIN_W'(1);

    ithr_cause_regs #(.CAUSE_W(CAUSE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cause_rd),
        .set_bits   (post_valid ? post_bits : '0),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .cause      (cause),
        .cause_nx   (cause_nx),
        .mask_nx    (mask_nx)
    );

    ithr_age #(.AGE_W(WIN_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_deliver),
        .age     (age)
    );

    ithr_countdown #(.CNT_W(WIN_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .at_zero  (cd_zero)
    );

    assign elapsed = (itr_interval == '0) || post_urgent || (age >= window);
    assign fire    = (state == ST_ARMED) && cd_zero;
    assign attempt = (post_valid && elapsed) || fire;
    assign pending = |(cause_nx & mask_nx);

    // next state and actions
    always_comb begin
        state_nx   = state;
        do_deliver = 1'b0;
        load       = 1'b0;
        load_val   = '0;
        if (attempt) begin
            if (pending) begin
                do_deliver = 1'b1;             // post-deliver / timer-fire
                state_nx   = ST_ASSERTED;
            end else begin
                state_nx   = ST_IDLE;          // attempt with nothing unmasked
            end
        end else if ((cause_rd || mask_wr) && !pending) begin
            state_nx = ST_IDLE;                // clear-drop
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (post_valid) begin
                        load     = 1'b1;       // post-defer
                        load_val = post_load;
                        state_nx = ST_ARMED;
                    end else if (mask_wr && pending) begin
                        load     = 1'b1;       // mask-arm
                        load_val = mask_load;
                        state_nx = ST_ARMED;
                    end
                end
                ST_ARMED:    state_nx = ST_ARMED;
                ST_ASSERTED: state_nx = ST_ASSERTED;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver_pulse <= 1'b0;
            attempt_count <= '0;
        end else begin
            deliver_pulse <= do_deliver;
            if (attempt) attempt_count <= attempt_count + CNT_W'(1);
        end
    end

    assign irq     = (state == ST_ASSERTED);
    assign rd_data = {irq, cause};
endmodule

// File: rtl/ithr_ctrl_chk.sv
module ithr_ctrl_chk #(
    parameter int CAUSE_W = 8,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_valid,
    input logic               post_urgent,
    input logic [CAUSE_W-1:0] post_bits,
    input logic               cause_rd,
    input logic               mask_wr,
    input logic [CAUSE_W-1:0] mask_wdata,
    input logic [CAUSE_W:0]   rd_data,
    input logic               irq,
    input logic               deliver_pulse,
    input logic [CNT_W-1:0]   attempt_count
);
    assert_post_sets_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> ((rd_data[CAUSE_W-1:0] & $past(post_bits)) == $past(post_bits)));

    assert_urgent_attempts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && post_urgent) |=> (attempt_count == $past(attempt_count) + CNT_W'(1)));

    assert_pulse_counted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_pulse |-> (attempt_count == $past(attempt_count) + CNT_W'(1)));

    assert_pulse_raises_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_pulse |-> (irq && rd_data[CAUSE_W]));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && !post_valid) |=> (rd_data[CAUSE_W-1:0] == '0) && !irq);

    assert_mask_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !post_valid && ((mask_wdata & rd_data[CAUSE_W-1:0]) == '0)) |=> !irq);
endmodule

bind ithr_ctrl ithr_ctrl_chk #(.CAUSE_W(CAUSE_W), .CNT_W(CNT_W)) u_ithr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .post_valid    (post_valid),
    .post_urgent   (post_urgent),
    .post_bits     (post_bits),
    .cause_rd      (cause_rd),
    .mask_wr       (mask_wr),
    .mask_wdata    (mask_wdata),
    .rd_data       (rd_data),
    .irq           (irq),
    .deliver_pulse (deliver_pulse),
    .attempt_count (attempt_count)
);

// File: tb/test_ithr_ctrl.sv
`timescale 1ns/1ps
module test_ithr_ctrl;
    localparam int CW = 8;
    localparam int IW = 8;
    localparam int TL = 2;
    localparam int IVL = 3;
    localparam int W = IVL << TL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] itr_interval = '0;
    logic          post_valid = 1'b0;
    logic [CW-1:0] post_bits = '0;
    logic          post_urgent = 1'b0;
    logic          cause_rd = 1'b0;
    logic          mask_wr = 1'b0;
    logic [CW-1:0] mask_wdata = '0;
    logic [CW:0]   rd_data;
    logic          irq, deliver_pulse;
    logic [31:0]   attempt_count;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_pulse = 0;
    int exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ithr_ctrl #(.CAUSE_W(CW), .IVL_W(IW), .TICK_LOG2(TL), .CNT_W(32)) i_ithr_ctrl (
        .clk(clk), .rst_n(rst_n), .itr_interval(itr_interval),
        .post_valid(post_valid), .post_bits(post_bits), .post_urgent(post_urgent),
        .cause_rd(cause_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .rd_data(rd_data), .irq(irq), .deliver_pulse(deliver_pulse),
        .attempt_count(attempt_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: each pulse must match the next expected cycle
    always @(negedge clk) begin
        if (rst_n && deliver_pulse) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R5/R11 unexpected pulse actual=%0d expected=none", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    n_bad++;
                    $display("FAIL R5/R12 pulse cycle actual=%0d expected=%0d", cyc, e);
                end
            end
            last_pulse = cyc;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic post(input logic [CW-1:0] b, input logic urg, output int n);
        step();
        post_valid = 1'b1; post_bits = b; post_urgent = urg; n = cyc;
        step();
        post_valid = 1'b0; post_bits = '0; post_urgent = 1'b0;
    endtask

    task automatic mask_write(input logic [CW-1:0] m, output int n);
        step();
        mask_wr = 1'b1; mask_wdata = m; n = cyc;
        step();
        mask_wr = 1'b0;
    endtask

    task automatic read_clear();
        step(); cause_rd = 1'b1;
        step(); cause_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rd_data", {23'd0, rd_data}, 32'd0);
        check("R1 count", attempt_count, 32'd0);

        // R3: zero interval, immediate delivery
        mask_write(8'hFF, n);
        step(); post_valid = 1'b1; post_bits = 8'h01; exp_q.push_back(cyc + 1);
        step(); post_valid = 1'b0; post_bits = '0;
        @(negedge clk);
        check("R3 irq", {31'd0, irq}, 32'd1);
        check("R9 rd_data", {23'd0, rd_data}, 32'h101);
        check("R8 count", attempt_count, 32'd1);

        // R10: read returns value and clears
        step(); cause_rd = 1'b1;
        @(negedge clk);
        check("R10 read value", {23'd0, rd_data}, 32'h101);
        step(); cause_rd = 1'b0;
        @(negedge clk);
        check("R10 cleared", {23'd0, rd_data}, 32'h000);
        check("R10 irq low", {31'd0, irq}, 32'd0);

        // R4: urgent bypass
        itr_interval = IVL[IW-1:0];
        step(); post_valid = 1'b1; post_bits = 8'h02; post_urgent = 1'b1; exp_q.push_back(cyc + 1);
        step(); post_valid = 1'b0; post_bits = '0; post_urgent = 1'b0;
        @(negedge clk);
        check("R4 irq", {31'd0, irq}, 32'd1);
        check("R4 count", attempt_count, 32'd2);

        // R5/R7: deferred delivery timed from last delivery
        read_clear();
        step();
        exp_q.push_back(last_pulse + W + 1);
        post(8'h04, 1'b0, n);
        @(negedge clk);
        check("R5 deferred irq low", {31'd0, irq}, 32'd0);
        step();
        post(8'h08, 1'b0, n);
        repeat (W + 4) step();
        @(negedge clk);
        check("R5 count", attempt_count, 32'd3);
        check("R7 rd_data", {23'd0, rd_data}, 32'h10C);

        // R6: post after the window elapsed
        read_clear();
        repeat (W + 8) step();
        step(); post_valid = 1'b1; post_bits = 8'h10; exp_q.push_back(cyc + 1);
        step(); post_valid = 1'b0; post_bits = '0;
        @(negedge clk);
        check("R6 irq", {31'd0, irq}, 32'd1);
        check("R6 count", attempt_count, 32'd4);

        // R8: attempt with nothing unmasked
        read_clear();
        mask_write(8'h00, n);
        repeat (W + 8) step();
        post(8'h20, 1'b0, n);
        @(negedge clk);
        check("R8 count", attempt_count, 32'd5);
        check("R8 irq", {31'd0, irq}, 32'd0);
        check("R2 rd_data", {23'd0, rd_data}, 32'h020);

        // R12: mask write uncovers pending cause
        step(); mask_wr = 1'b1; mask_wdata = 8'h20; exp_q.push_back(cyc + W + 1);
        step(); mask_wr = 1'b0;
        @(negedge clk);
        check("R12 irq low", {31'd0, irq}, 32'd0);
        repeat (W + 2) step();
        @(negedge clk);
        check("R12 irq", {31'd0, irq}, 32'd1);
        check("R12 count", attempt_count, 32'd6);

        // R11: cancel of an armed deferred delivery
        read_clear();
        mask_write(8'h40, n);
        post(8'h40, 1'b0, n);
        step();
        mask_write(8'h00, n);
        repeat (W + 8) step();
        @(negedge clk);
        check("R11 irq", {31'd0, irq}, 32'd0);
        check("R11 count", attempt_count, 32'd6);
        check("R11 rd_data", {23'd0, rd_data}, 32'h040);

        // R11: mask drop deasserts the line
        step(); mask_wr = 1'b1; mask_wdata = 8'h40; exp_q.push_back(cyc + W + 1);
        step(); mask_wr = 1'b0;
        repeat (W + 2) step();
        @(negedge clk);
        check("R12 irq rearm", {31'd0, irq}, 32'd1);
        check("R12 count", attempt_count, 32'd7);
        mask_write(8'h00, n);
        @(negedge clk);
        check("R11 deassert", {31'd0, irq}, 32'd0);

        repeat (4) step();
        check("R5 queue empty", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule